// File: doc/BRIEF.md
# ACPI Power-Management Control and Mode Switch Port

This block holds the 16-bit power-management control word of an ACPI-style platform, and a byte-wide command port that switches the platform between legacy mode and ACPI mode. Both sit on a simple single-beat I/O register bus. Each access carries an address, a direction, a size code and write data. One cycle later the block returns read data and an error flag.

The command port accepts writes only. One command code puts the platform into ACPI mode: it sets the interrupt-enable bit of the control word and arms the power-button event source. A second code undoes both. Software cannot change the interrupt-enable bit through the control word itself.

The control word holds a 3-bit sleep type. It also has a trigger bit that is never stored. When a write carries the trigger bit together with sleep type 5 (soft off), the block emits a one-cycle power-off request. Other sleep types are stored but cause nothing.

Top module: `acpi_pmc`

## Requirements
- R1: After reset, the control word reads 0x0000, `sci_en`, `pwrbtn_armed` and `poweroff_req` are 0, and no error is flagged.
- R2: A 2-byte write (`bus_size`=1) to the control address stores the write data ANDed with 0x1FFC. Bit 0 (interrupt enable) keeps its previous value. Bits 15, 14, 13 and 1 store as 0.
- R3: A 2-byte read of the control address returns the stored word on `bus_rdata` in the cycle after the access. Bit 13 (sleep trigger) always reads 0. Bit 0 equals `sci_en`.
- R4: A control write with bit 13 set and bits 12:10 equal to 5 raises `poweroff_req` in the cycle after the access, for exactly one cycle.
- R5: A control write with bit 13 clear, or with bits 12:10 not equal to 5, leaves `poweroff_req` low.
- R6: A control access of any size other than 2 bytes raises `bus_err` in the following cycle, returns 0, and leaves the control word unchanged. The size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = reserved.
- R7: A 1-byte write of code 0xA0 to the command address sets `sci_en` (control bit 0) and `pwrbtn_armed`. Both are visible in the cycle after the access.
- R8: A 1-byte write of code 0xA1 to the command address clears `sci_en` and `pwrbtn_armed`.
- R9: A 1-byte write of any other code to the command address changes nothing and raises no error.
- R10: Any read of the command address, or any write to it with a size other than 1 byte, raises `bus_err`, returns 0 and changes nothing.
- R11: An access to any other address raises no error, returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | I/O address |
| bus_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| bus_wdata | input | 16 | Write data; the command port uses bits 7:0 |
| bus_rdata | output | 16 | Read data, valid the cycle after the access |
| bus_err | output | 1 | Wrong size or direction, valid the cycle after the access |
| sci_en | output | 1 | ACPI mode active (control bit 0) |
| pwrbtn_armed | output | 1 | Power-button event source armed |
| poweroff_req | output | 1 | One-cycle soft-off request |

## Verification
A corrupted control word appears on the next control read. A wrongly set or cleared mode bit appears at once on `sci_en` and `pwrbtn_armed`, one cycle after the command that caused it. A spurious or stretched power-off request shows on `poweroff_req` in the cycle after the offending write, or one cycle later. Every access in the random stream is followed by a check of all outputs one cycle after it. A stray state change is therefore caught within one access of its cause.

// File: rtl/acpi_pmc_pkg.sv
package acpi_pmc_pkg;

   localparam int unsigned CTL_W       = 16;
   localparam int unsigned CMD_W       = 8;
   localparam int unsigned SCI_BIT     = 0;
   localparam int unsigned TRIG_BIT    = 13;
   localparam int unsigned STYPE_LO    = 10;
   localparam int unsigned STYPE_W     = 3;
   localparam logic [CTL_W-1:0] ZERO_MASK = 16'hC003;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_RSVD  = 2'd3
   } acc_size_e;

   typedef struct packed {
      logic ctl_wr;
      logic ctl_rd;
      logic cmd_wr;
      logic bad;
   } acc_dec_t;

endpackage

// File: rtl/pmc_bus_decode.sv
module pmc_bus_decode
   import acpi_pmc_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h0404,
   parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h00B2
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output acc_dec_t          dec
);

   initial begin
      if (CTL_ADDR == CMD_ADDR)
         $error("control and command addresses must differ");
   end

   logic hit_ctl, hit_cmd, ctl_size_ok, cmd_size_ok;

   always_comb begin
      hit_ctl     = sel && (addr == CTL_ADDR);
      hit_cmd     = sel && (addr == CMD_ADDR);
      ctl_size_ok = (acc_size_e'(size) == SZ_WORD);
      cmd_size_ok = (acc_size_e'(size) == SZ_BYTE) && wr;
      dec.ctl_wr  = hit_ctl && ctl_size_ok && wr;
      dec.ctl_rd  = hit_ctl && ctl_size_ok && !wr;
      dec.cmd_wr  = hit_cmd && cmd_size_ok;
      dec.bad     = (hit_ctl && !ctl_size_ok) || (hit_cmd && !cmd_size_ok);
   end

endmodule

// File: rtl/pmc_cmd_port.sv
module pmc_cmd_port
   import acpi_pmc_pkg::*;
#(
   parameter logic [CMD_W-1:0] ON_CODE  = 8'hA0,
   parameter logic [CMD_W-1:0] OFF_CODE = 8'hA1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CMD_W-1:0] code,
   output logic             mode_on,
   output logic             mode_off,
   output logic             armed
);

   initial begin
      if (ON_CODE == OFF_CODE)
         $error("mode-on and mode-off codes must differ");
   end

   always_comb begin
      mode_on  = wr_en && (code == ON_CODE);
      mode_off = wr_en && (code == OFF_CODE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        armed <= 1'b0;
      else if (mode_on)  armed <= 1'b1;
      else if (mode_off) armed <= 1'b0;
   end

   AST_ARM_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(armed) |-> $past(mode_on || mode_off)); // R7

endmodule

// File: rtl/pmc_ctl_reg.sv
module pmc_ctl_reg
   import acpi_pmc_pkg::*;
#(
   parameter logic [STYPE_W-1:0] OFF_TYPE = 3'd5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wdata,
   input  logic             sci_set,
   input  logic             sci_clr,
   output logic [CTL_W-1:0] ctl_q,
   output logic             poweroff
);

   localparam logic [CTL_W-1:0] TRIG_MASK  = CTL_W'(1) << TRIG_BIT;
   localparam logic [CTL_W-1:0] STORE_MASK = ~(ZERO_MASK | TRIG_MASK);

   logic [CTL_W-1:0]   ctl_d;
   logic [STYPE_W-1:0] new_type;
   logic               off_hit;

   always_comb begin
      ctl_d = ctl_q;
      if (wr_en)
         ctl_d = (ctl_q & (CTL_W'(1) << SCI_BIT)) | (wdata & STORE_MASK);
      if (sci_set) ctl_d[SCI_BIT] = 1'b1;
      if (sci_clr) ctl_d[SCI_BIT] = 1'b0;
      new_type = wdata[STYPE_LO +: STYPE_W];
      off_hit  = wr_en && wdata[TRIG_BIT] && (new_type == OFF_TYPE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q    <= '0;
         poweroff <= 1'b0;
      end else begin
         ctl_q    <= ctl_d;
         poweroff <= off_hit;
      end
   end

   AST_TRIG_NEVER_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !ctl_q[TRIG_BIT]); // R3
   AST_SCI_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctl_q[SCI_BIT]) |-> $past(sci_set || sci_clr)); // R2
   AST_OFF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      poweroff |=> !poweroff); // R4
   AST_OFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      poweroff |-> $past(wr_en && wdata[TRIG_BIT]
                         && wdata[STYPE_LO +: STYPE_W] == OFF_TYPE)); // R5

endmodule

// File: rtl/acpi_pmc.sv
module acpi_pmc
   import acpi_pmc_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h0404,
   parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h00B2,
   parameter logic [7:0]        ON_CODE  = 8'hA0,
   parameter logic [7:0]        OFF_CODE = 8'hA1,
   parameter bit                RD_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              bus_err,
   output logic              sci_en,
   output logic              pwrbtn_armed,
   output logic              poweroff_req
);

   initial begin
      if (CTL_W != 16) $error("control word must be 16 bits");
      if (ADDR_W < 2)  $error("address width too small");
   end

   acc_dec_t         dec;
   logic             mode_on, mode_off;
   logic [CTL_W-1:0] ctl_q;
   logic [CTL_W-1:0] rd_val;

   pmc_bus_decode #(
      .ADDR_W  (ADDR_W),
      .CTL_ADDR(CTL_ADDR),
      .CMD_ADDR(CMD_ADDR)
   ) u_dec (
      .sel (bus_sel),
      .wr  (bus_wr),
      .addr(bus_addr),
      .size(bus_size),
      .dec (dec)
   );

   pmc_cmd_port #(
      .ON_CODE (ON_CODE),
      .OFF_CODE(OFF_CODE)
   ) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dec.cmd_wr),
      .code    (bus_wdata[CMD_W-1:0]),
      .mode_on (mode_on),
      .mode_off(mode_off),
      .armed   (pwrbtn_armed)
   );

   pmc_ctl_reg u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dec.ctl_wr),
      .wdata   (bus_wdata),
      .sci_set (mode_on),
      .sci_clr (mode_off),
      .ctl_q   (ctl_q),
      .poweroff(poweroff_req)
   );

   assign sci_en = ctl_q[SCI_BIT];
   assign rd_val = dec.ctl_rd ? ctl_q : '0;

   generate
      if (RD_REG) begin : g_rd_reg
         logic [CTL_W-1:0] rdata_q;
         logic             err_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rdata_q <= '0;
               err_q   <= 1'b0;
            end else begin
               rdata_q <= rd_val;
               err_q   <= dec.bad;
            end
         end
         assign bus_rdata = rdata_q;
         assign bus_err   = err_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_val;
         assign bus_err   = dec.bad;
      end
   endgenerate

   AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $stable(ctl_q)); // R6
   AST_ERR_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> bus_rdata == '0); // R10
   AST_MODE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      sci_en == pwrbtn_armed); // R8

endmodule

// File: tb/test_acpi_pmc.sv
module test_acpi_pmc;

   localparam logic [15:0] CTL_A = 16'h0404;
   localparam logic [15:0] CMD_A = 16'h00B2;
   localparam logic [15:0] OTH_A = 16'h0400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [15:0] bus_addr = '0, bus_wdata = '0;
   logic [1:0]  bus_size = '0;
   logic [15:0] bus_rdata;
   logic        bus_err, sci_en, pwrbtn_armed, poweroff_req;

   int total = 0, bad = 0;
   logic [15:0] m_ctl = '0;
   logic        m_sci = 1'b0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   acpi_pmc i_acpi_pmc (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .sci_en(sci_en),
      .pwrbtn_armed(pwrbtn_armed), .poweroff_req(poweroff_req)
   );

   function automatic logic [15:0] f_ctl_next(logic [15:0] old, logic [15:0] wd);
      return (old & 16'h0001) | (wd & 16'h1FFC);
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(logic wr, logic [15:0] a, logic [1:0] sz, logic [15:0] wd);
      logic        e_err, e_off;
      logic [15:0] e_rd;
      e_err = 1'b0; e_off = 1'b0; e_rd = '0;
      if (a == CTL_A) begin
         if (sz != 2'd1) e_err = 1'b1;
         else if (wr) begin
            m_ctl = f_ctl_next(m_ctl, wd);
            e_off = wd[13] && (wd[12:10] == 3'd5);
         end else e_rd = m_ctl;
      end else if (a == CMD_A) begin
         if (!wr || sz != 2'd0) e_err = 1'b1;
         else if (wd[7:0] == 8'hA0) begin m_sci = 1'b1; m_ctl[0] = 1'b1; end
         else if (wd[7:0] == 8'hA1) begin m_sci = 1'b0; m_ctl[0] = 1'b0; end
      end
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
      @(negedge clk);
      bus_sel = 1'b0;
      check(a == CTL_A ? (sz == 2'd1 ? "R3" : "R6") :
            a == CMD_A ? "R10" : "R11", {15'd0, bus_err}, {15'd0, e_err});
      check(a == CTL_A ? "R3" : "R10", bus_rdata, e_rd);
      check(e_off ? "R4" : "R5", {15'd0, poweroff_req}, {15'd0, e_off});
      check("R7", {15'd0, sci_en}, {15'd0, m_sci});
      check("R8", {15'd0, pwrbtn_armed}, {15'd0, m_sci});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] a, wd;
      logic [1:0]  sz;
      logic        wr;
      int unsigned seed;
      seed = 32'd12345;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", {15'd0, sci_en}, 16'd0);
      check("R1", {15'd0, pwrbtn_armed}, 16'd0);
      check("R1", {15'd0, poweroff_req}, 16'd0);
      check("R1", {15'd0, bus_err}, 16'd0);
      access(1'b0, CTL_A, 2'd1, 16'h0);
      // R2 masking with SCI preserved
      access(1'b1, CTL_A, 2'd1, 16'hFFFF);
      access(1'b0, CTL_A, 2'd1, 16'h0);
      // R7 enable, then R2 write cannot clear bit 0
      access(1'b1, CMD_A, 2'd0, 16'h00A0);
      access(1'b1, CTL_A, 2'd1, 16'h0000);
      access(1'b0, CTL_A, 2'd1, 16'h0);
      // R4 soft-off and single-cycle pulse
      access(1'b1, CTL_A, 2'd1, 16'h3400);
      @(negedge clk);
      check("R4", {15'd0, poweroff_req}, 16'd0);
      // R5 type 5 without trigger, trigger with type 4
      access(1'b1, CTL_A, 2'd1, 16'h1400);
      access(1'b1, CTL_A, 2'd1, 16'h3000);
      // R6 wrong sizes
      access(1'b1, CTL_A, 2'd0, 16'h1234);
      access(1'b0, CTL_A, 2'd2, 16'h0);
      access(1'b0, CTL_A, 2'd1, 16'h0);
      // R9, R10, R11
      access(1'b1, CMD_A, 2'd0, 16'h00A2);
      access(1'b0, CMD_A, 2'd0, 16'h0);
      access(1'b1, CMD_A, 2'd1, 16'h00A1);
      access(1'b1, OTH_A, 2'd1, 16'hFFFF);
      access(1'b0, OTH_A, 2'd1, 16'h0);
      // R8 disable
      access(1'b1, CMD_A, 2'd0, 16'h00A1);
      access(1'b0, CTL_A, 2'd1, 16'h0);
      for (int i = 0; i < 400; i++) begin
         case ($urandom % 5)
            0, 1:    a = CTL_A;
            2, 3:    a = CMD_A;
            default: a = OTH_A;
         endcase
         wr = ($urandom % 4) != 0;
         sz = (($urandom % 4) == 0) ? 2'($urandom) : (a == CMD_A ? 2'd0 : 2'd1);
         wd = 16'($urandom);
         if (a == CMD_A && ($urandom % 2)) wd[7:0] = 8'hA0 | 8'($urandom % 2);
         if (a == CTL_A && ($urandom % 3) == 0) wd[12:10] = 3'd5;
         access(wr, a, sz, wd);
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule